// File: doc/BRIEF.md
# Fetch Group Builder with Predicted-Branch Cut

This block sits in an instruction fetch stage between a one-line instruction buffer and the decode queue. In each cycle that fetch is enabled and the buffered line covers the current fetch address, it cuts a group of up to `W` sequential 32-bit instructions out of the line. Each emitted instruction is tagged with its own address and with the address predicted to follow it. The block keeps the thread's current PC and next-PC as an explicit pair. When a group completes, it writes that pair back from the last emitted instruction.

A group ends at one of four points: the end of the line, the width limit, the first instruction whose predicted successor is not the next sequential word, or a quiesce instruction. The instruction that causes the cut is still emitted. Branch prediction is supplied from outside, one entry per output slot: a control flag, a taken flag and a target. Slot k's entry describes the k-th emitted instruction. When the buffered line does not cover the PC, the block emits nothing and raises a line request carrying the line-aligned fetch address. Servicing that request happens elsewhere. A redirect input overwrites the PC pair.

Top module: `fetch_group_builder`

## Requirements
- R1: After reset, the fetch PC is `RESET_PC`, the next-PC is `RESET_PC`+4, and next-next-PC is `RESET_PC`+8. With fetch disabled, no slot is valid and no line request is raised.
- R2: A hit occurs when fetch is enabled, no redirect is present, the line is valid, and the line base equals the PC with its low log2(`LINE_BYTES`) bits cleared. When fetch is enabled with no redirect and no hit, `line_req_o` is 1, no slot is valid and the PC pair is unchanged. `line_req_addr_o` always shows the line-aligned PC.
- R3: On a hit, slot 0 carries the line word selected by PC bits [log2(`LINE_BYTES`)-1:2], where word j occupies line bits [32j+31:32j]. Slot 0's address is the PC, and each further slot k carries word index+k at address PC+4k.
- R4: A group never runs past the last word of the line. If no earlier cut applies, it holds exactly `WORDS` minus the start word index instructions.
- R5: A group holds at most `W` instructions. A fully sequential run stops at `W`.
- R6: For a non-control instruction, the predicted next address is the current next-PC. If that differs from the instruction's address plus 4, the group ends after it.
- R7: For a control instruction, the predicted next address is the target when predicted taken, and address+4 otherwise. A taken prediction whose target is not address+4 ends the group after it, while a not-taken one lets the group continue.
- R8: An instruction whose quiesce bit is set is emitted and ends the group, and `quiesce_o` is 1 in that cycle.
- R9: After a group, the PC becomes the last slot's predicted next address and the next-PC becomes that value plus 4. `nnpc_o` always equals next-PC plus 4.
- R10: A redirect loads the PC and next-PC from the redirect inputs at the next edge. No slot is valid and no line request is raised in the redirect cycle, whatever the other inputs are.
- R11: With fetch disabled and no redirect, no slot is valid, no line request is raised and the PC pair is held.
- R12: Valid slots are contiguous from slot 0. An invalid slot drives zero on its instruction, address and predicted-address outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en_i | input | 1 | Thread selected and allowed to fetch this cycle |
| redirect_i | input | 1 | Load a new PC pair; suppresses fetch this cycle |
| redirect_pc_i | input | 32 | New PC |
| redirect_npc_i | input | 32 | New next-PC |
| line_valid_i | input | 1 | Buffered line holds valid data |
| line_base_i | input | 32 | Byte address of the buffered line |
| line_data_i | input | 8*LINE_BYTES | Buffered line, word j in bits 32j+31:32j |
| bp_ctrl_i | input | W | Per slot: instruction is a control transfer |
| bp_taken_i | input | W | Per slot: predicted taken |
| bp_target_i | input | 32*W | Per slot: predicted target |
| quiesce_i | input | W | Per slot: instruction is a quiesce instruction |
| slot_valid_o | output | W | Valid flags of the emitted slots |
| slot_inst_o | output | 32*W | Emitted instruction words |
| slot_pc_o | output | 32*W | Address of each emitted instruction |
| slot_pred_o | output | 32*W | Predicted next address of each instruction |
| line_req_o | output | 1 | Buffered line does not cover the PC |
| line_req_addr_o | output | 32 | Line-aligned PC for the request |
| quiesce_o | output | 1 | Group ended on a quiesce instruction |
| pc_o | output | 32 | Current fetch PC |
| npc_o | output | 32 | Current next-PC |
| nnpc_o | output | 32 | Next-PC plus 4 |

## Verification
A wrong PC pair shows up in the very next hit cycle. It appears as slot 0 carrying the wrong word or address, and as `pc_o`/`npc_o` off by the wrong amount one edge after a group. The reference model therefore compares every slot field and the PC pair on every cycle. A broken cut decision is visible in the same cycle as an extra or missing valid slot after a branch, a quiesce or the line end, and again one cycle later as a wrong write-back address. Directed sequences set up each cut reason at known offsets, including the last word of a line and a non-sequential next-PC. A long randomized run then mixes redirects, misses and predictions.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned INST_W     = 32;
  localparam int unsigned INST_BYTES = 4;
  localparam int unsigned INST_SHIFT = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [INST_W-1:0] inst_t;

  // Reason a fetch group stopped; exactly one per hit cycle.
  typedef enum logic [2:0] {
    END_NONE,
    END_LINE,
    END_WIDTH,
    END_TURN,
    END_QUIESCE
  } group_end_e;

  function automatic addr_t seq_next(addr_t a);
    return a + addr_t'(INST_BYTES);
  endfunction

  function automatic addr_t line_align(addr_t a, int unsigned loff);
    addr_t mask;
    mask = (addr_t'(1) << loff) - addr_t'(1);
    return a & ~mask;
  endfunction
endpackage

// File: rtl/fgb_line_match.sv
module fgb_line_match
  import fgb_pkg::*;
#(
  parameter int unsigned LOFF  = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic             fetch_en,
  input  logic             redirect,
  input  logic             line_valid,
  input  addr_t            line_base,
  input  addr_t            pc,
  output logic             hit,
  output logic             req,
  output addr_t            req_addr,
  output logic [IDX_W-1:0] start_word
);
  logic  want;
  logic  covers;
  addr_t aligned;

  always_comb begin
    aligned    = line_align(pc, LOFF);
    want       = fetch_en && !redirect;
    covers     = line_valid && (line_base == aligned);
    hit        = want && covers;
    req        = want && !covers;
    req_addr   = aligned;
    start_word = pc[LOFF-1:INST_SHIFT];
  end
endmodule

// File: rtl/fgb_slot_step.sv
module fgb_slot_step
  import fgb_pkg::*;
#(
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                    alive_in,
  input  logic [IDX_W:0]          pos,
  input  logic [WORDS*INST_W-1:0] line,
  input  addr_t                   in_pc,
  input  addr_t                   in_npc,
  input  logic                    is_ctrl,
  input  logic                    taken,
  input  addr_t                   target,
  input  logic                    quiesce,
  output logic                    valid,
  output inst_t                   inst,
  output addr_t                   slot_pc,
  output addr_t                   pred,
  output addr_t                   out_pc,
  output addr_t                   out_npc,
  output logic                    alive_out,
  output group_end_e              cause
);
  logic  in_line;
  logic  last_word;
  logic  turn;
  addr_t seq;
  addr_t nxt;

  always_comb begin
    in_line   = pos < (IDX_W+1)'(WORDS);
    last_word = pos == (IDX_W+1)'(WORDS - 1);
    valid     = alive_in && in_line;
    seq       = seq_next(in_pc);
    if (!is_ctrl)   nxt = in_npc;
    else if (taken) nxt = target;
    else            nxt = seq;
    turn      = nxt != seq;

    inst      = '0;
    slot_pc   = '0;
    pred      = '0;
    out_pc    = in_pc;
    out_npc   = in_npc;
    alive_out = 1'b0;
    cause     = END_NONE;
    if (valid) begin
      inst    = line[int'(pos[IDX_W-1:0])*INST_W +: INST_W];
      slot_pc = in_pc;
      pred    = nxt;
      out_pc  = nxt;
      out_npc = seq_next(nxt);
      if (quiesce)        cause = END_QUIESCE;
      else if (turn)      cause = END_TURN;
      else if (last_word) cause = END_LINE;
      else                alive_out = 1'b1;
    end
  end
endmodule

// File: rtl/fgb_pc_state.sv
module fgb_pc_state
  import fgb_pkg::*;
#(
  parameter addr_t RESET_PC = 32'h0000_1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_redirect,
  input  addr_t redirect_pc,
  input  addr_t redirect_npc,
  input  logic  load_group,
  input  addr_t group_pc,
  input  addr_t group_npc,
  output addr_t pc_q,
  output addr_t npc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      npc_q <= seq_next(RESET_PC);
    end else if (load_redirect) begin
      pc_q  <= redirect_pc;
      npc_q <= redirect_npc;
    end else if (load_group) begin
      pc_q  <= group_pc;
      npc_q <= group_npc;
    end
  end
endmodule

// File: rtl/fetch_group_builder.sv
module fetch_group_builder
  import fgb_pkg::*;
#(
  parameter int unsigned W          = 4,
  parameter int unsigned LINE_BYTES = 32,
  parameter logic [31:0] RESET_PC   = 32'h0000_1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_en_i,
  input  logic                  redirect_i,
  input  logic [31:0]           redirect_pc_i,
  input  logic [31:0]           redirect_npc_i,
  input  logic                  line_valid_i,
  input  logic [31:0]           line_base_i,
  input  logic [8*LINE_BYTES-1:0] line_data_i,
  input  logic [W-1:0]          bp_ctrl_i,
  input  logic [W-1:0]          bp_taken_i,
  input  logic [32*W-1:0]       bp_target_i,
  input  logic [W-1:0]          quiesce_i,
  output logic [W-1:0]          slot_valid_o,
  output logic [32*W-1:0]       slot_inst_o,
  output logic [32*W-1:0]       slot_pc_o,
  output logic [32*W-1:0]       slot_pred_o,
  output logic                  line_req_o,
  output logic [31:0]           line_req_addr_o,
  output logic                  quiesce_o,
  output logic [31:0]           pc_o,
  output logic [31:0]           npc_o,
  output logic [31:0]           nnpc_o
);
  localparam int unsigned WORDS = LINE_BYTES / INST_BYTES;
  localparam int unsigned LOFF  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W = $clog2(WORDS);

  addr_t            pc_q, npc_q;
  logic             hit_w;
  logic [IDX_W-1:0] start_word;
  addr_t            chain_pc  [W+1];
  addr_t            chain_npc [W+1];
  logic [W:0]       alive;
  group_end_e       slot_end  [W];
  group_end_e       group_end;
  logic [W-1:0]     slot_q;

  fgb_line_match #(.LOFF(LOFF), .IDX_W(IDX_W)) u_match (
    .fetch_en   (fetch_en_i),
    .redirect   (redirect_i),
    .line_valid (line_valid_i),
    .line_base  (line_base_i),
    .pc         (pc_q),
    .hit        (hit_w),
    .req        (line_req_o),
    .req_addr   (line_req_addr_o),
    .start_word (start_word)
  );

  assign alive[0]     = hit_w;
  assign chain_pc[0]  = pc_q;
  assign chain_npc[0] = npc_q;

  for (genvar k = 0; k < W; k++) begin : g_slot
    logic [IDX_W:0] pos;
    logic           v;
    assign pos = {1'b0, start_word} + (IDX_W+1)'(k);

    fgb_slot_step #(.WORDS(WORDS), .IDX_W(IDX_W)) u_step (
      .alive_in  (alive[k]),
      .pos       (pos),
      .line      (line_data_i),
      .in_pc     (chain_pc[k]),
      .in_npc    (chain_npc[k]),
      .is_ctrl   (bp_ctrl_i[k]),
      .taken     (bp_taken_i[k]),
      .target    (bp_target_i[k*32 +: 32]),
      .quiesce   (quiesce_i[k]),
      .valid     (v),
      .inst      (slot_inst_o[k*32 +: 32]),
      .slot_pc   (slot_pc_o[k*32 +: 32]),
      .pred      (slot_pred_o[k*32 +: 32]),
      .out_pc    (chain_pc[k+1]),
      .out_npc   (chain_npc[k+1]),
      .alive_out (alive[k+1]),
      .cause     (slot_end[k])
    );
    assign slot_valid_o[k] = v;
    assign slot_q[k]       = v && quiesce_i[k];
  end

  always_comb begin
    group_end = END_NONE;
    for (int k = 0; k < W; k++) begin
      if (slot_end[k] != END_NONE) group_end = slot_end[k];
    end
    if (alive[W]) group_end = END_WIDTH;
  end

  assign quiesce_o = |slot_q;

  fgb_pc_state #(.RESET_PC(RESET_PC)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_redirect (redirect_i),
    .redirect_pc   (redirect_pc_i),
    .redirect_npc  (redirect_npc_i),
    .load_group    (hit_w),
    .group_pc      (chain_pc[W]),
    .group_npc     (chain_npc[W]),
    .pc_q          (pc_q),
    .npc_q         (npc_q)
  );

  assign pc_o   = pc_q;
  assign npc_o  = npc_q;
  assign nnpc_o = seq_next(npc_q);
endmodule

// File: rtl/fetch_group_builder_chk.sv
module fetch_group_builder_chk
  import fgb_pkg::*;
#(
  parameter int unsigned W     = 4,
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_en_i,
  input logic             redirect_i,
  input logic [31:0]      redirect_pc_i,
  input logic [31:0]      redirect_npc_i,
  input logic [W-1:0]     slot_valid_o,
  input logic [31:0]      slot0_pc,
  input logic             line_req_o,
  input logic             quiesce_o,
  input logic [31:0]      pc_o,
  input logic [31:0]      npc_o,
  input logic             hit_w,
  input logic [IDX_W-1:0] start_word,
  input group_end_e       group_end
);
  logic [W-1:0] vplus;
  int           remain;
  assign vplus  = slot_valid_o + W'(1);
  assign remain = int'(WORDS) - int'(start_word);

  assert_contig_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid_o & vplus) == '0);

  assert_miss_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_i && !redirect_i && !hit_w) |-> (line_req_o && slot_valid_o == '0));

  assert_hit_noreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |-> (!line_req_o && slot_valid_o[0]));

  assert_redirect_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (pc_o == $past(redirect_pc_i) && npc_o == $past(redirect_npc_i)));

  assert_redirect_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |-> (slot_valid_o == '0 && !line_req_o));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en_i && !redirect_i) |=> ($stable(pc_o) && $stable(npc_o)));

  assert_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !redirect_i) |=> (npc_o == pc_o + 32'd4));

  assert_line_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (group_end == END_LINE) |-> ($countones(slot_valid_o) == remain));

  assert_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (group_end == END_WIDTH) |-> (&slot_valid_o));

  assert_quiesce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_o |-> (group_end == END_QUIESCE));

  assert_slot0_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid_o[0] |-> (slot0_pc == pc_o));
endmodule

bind fetch_group_builder fetch_group_builder_chk #(
  .W(W), .WORDS(WORDS), .IDX_W(IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_en_i     (fetch_en_i),
  .redirect_i     (redirect_i),
  .redirect_pc_i  (redirect_pc_i),
  .redirect_npc_i (redirect_npc_i),
  .slot_valid_o   (slot_valid_o),
  .slot0_pc       (slot_pc_o[31:0]),
  .line_req_o     (line_req_o),
  .quiesce_o      (quiesce_o),
  .pc_o           (pc_o),
  .npc_o          (npc_o),
  .hit_w          (hit_w),
  .start_word     (start_word),
  .group_end      (group_end)
);

// File: tb/fetch_group_builder_tb.sv
`timescale 1ns/1ps
module fetch_group_builder_tb;
  localparam int W  = 4;
  localparam int LB = 32;
  localparam int NW = LB / 4;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            en, redir, lvalid;
  logic [31:0]     rpc, rnpc, lbase;
  logic [8*LB-1:0] ldata;
  logic [W-1:0]    ctrl, tkn, qz;
  logic [32*W-1:0] tgt;
  logic [W-1:0]    s_valid;
  logic [32*W-1:0] s_inst, s_pc, s_pred;
  logic            req, q_out;
  logic [31:0]     req_addr, pc_o, npc_o, nnpc_o;

  fetch_group_builder #(.W(W), .LINE_BYTES(LB), .RESET_PC(RPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_en_i(en), .redirect_i(redir),
    .redirect_pc_i(rpc), .redirect_npc_i(rnpc), .line_valid_i(lvalid),
    .line_base_i(lbase), .line_data_i(ldata), .bp_ctrl_i(ctrl),
    .bp_taken_i(tkn), .bp_target_i(tgt), .quiesce_i(qz),
    .slot_valid_o(s_valid), .slot_inst_o(s_inst), .slot_pc_o(s_pc),
    .slot_pred_o(s_pred), .line_req_o(req), .line_req_addr_o(req_addr),
    .quiesce_o(q_out), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o)
  );

  function automatic logic [31:0] lword(logic [31:0] base, int j);
    return base ^ (32'h0101_0100 * 32'(j + 1)) ^ 32'h5A00_00C3;
  endfunction

  always_comb
    for (int j = 0; j < NW; j++) ldata[j*32 +: 32] = lword(lbase, j);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] m_pc  = RPC;
  logic [31:0] m_npc = RPC + 32'd4;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    en = 0; redir = 0; lvalid = 0; rpc = 0; rnpc = 0; lbase = 0;
    ctrl = 0; tkn = 0; qz = 0; tgt = 0;
  endtask

  // Behavioural reference: walk the line word by word from the PC.
  task automatic run_cycle(string tag);
    logic [W-1:0] ev;
    logic [31:0]  ei [W];
    logic [31:0]  ep [W];
    logic [31:0]  ed [W];
    logic [31:0]  p, n, np, aligned;
    bit           hit, go, eq;
    int           first;
    #1;
    ev = '0; eq = 0;
    for (int k = 0; k < W; k++) begin ei[k] = 0; ep[k] = 0; ed[k] = 0; end
    aligned = m_pc & ~32'(LB - 1);
    hit = en && !redir && lvalid && (lbase == aligned);
    p = m_pc; n = m_npc; go = hit;
    first = int'((m_pc % LB) / 4);
    for (int k = 0; k < W; k++) begin
      if (go && (first + k) < NW) begin
        ev[k] = 1'b1;
        ei[k] = lword(lbase, first + k);
        ep[k] = p;
        if (!ctrl[k])     np = n;
        else if (tkn[k])  np = tgt[k*32 +: 32];
        else              np = p + 4;
        ed[k] = np;
        if (qz[k]) eq = 1;
        go = (np == p + 4) && !qz[k];
        p = np; n = np + 4;
      end else go = 0;
    end
    chk(tag, "slot_valid", 32'(s_valid), 32'(ev));
    for (int k = 0; k < W; k++) begin
      if (ev[k]) begin
        chk(tag, "slot_inst", s_inst[k*32 +: 32], ei[k]);
        chk(tag, "slot_pc",   s_pc[k*32 +: 32],   ep[k]);
        chk(tag, "slot_pred", s_pred[k*32 +: 32], ed[k]);
      end else begin
        chk("R12", "idle slot inst", s_inst[k*32 +: 32], 0);
        chk("R12", "idle slot pc",   s_pc[k*32 +: 32],   0);
        chk("R12", "idle slot pred", s_pred[k*32 +: 32], 0);
      end
    end
    chk("R2", "line_req", 32'(req), 32'(en && !redir && !hit));
    chk("R2", "line_req_addr", req_addr, aligned);
    chk("R8", "quiesce", 32'(q_out), 32'(eq));
    chk("R9", "pc", pc_o, m_pc);
    chk("R9", "npc", npc_o, m_npc);
    chk("R9", "nnpc", nnpc_o, m_npc + 4);
    if (redir) begin m_pc = rpc; m_npc = rnpc; end
    else if (hit) begin m_pc = p; m_npc = n; end
    @(negedge clk);
  endtask

  task automatic hit_at(logic [31:0] base);
    en = 1; redir = 0; lvalid = 1; lbase = base;
  endtask

  task automatic redirect_to(logic [31:0] a, logic [31:0] b, string tag);
    idle_inputs(); redir = 1; rpc = a; rnpc = b;
    run_cycle(tag);
    redir = 0;
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset values visible while reset is held
    chk("R1", "pc in reset", pc_o, RPC);
    chk("R1", "npc in reset", npc_o, RPC + 4);
    chk("R1", "nnpc in reset", nnpc_o, RPC + 8);
    chk("R1", "valid in reset", 32'(s_valid), 0);
    chk("R1", "req in reset", 32'(req), 0);
    rst_n = 1'b1;
    run_cycle("R1");

    // R11: fetch disabled although the line would hit
    lvalid = 1; lbase = RPC; run_cycle("R11"); run_cycle("R11");

    // R2: invalid line, then a line at the wrong base
    en = 1; lvalid = 0; run_cycle("R2");
    lvalid = 1; lbase = 32'h0000_2000; run_cycle("R2");

    // R10 then R5/R3: start at word 3, full width of sequential words
    redirect_to(32'h0000_100C, 32'h0000_1010, "R10");
    hit_at(32'h0000_1000); run_cycle("R5");
    // R4: PC now at word 7, only one word left in the line
    hit_at(32'h0000_1000); run_cycle("R4");
    hit_at(32'h0000_1020); run_cycle("R3");

    // R6: non-sequential next-PC on a plain instruction
    redirect_to(32'h0000_1040, 32'h0000_1080, "R10");
    hit_at(32'h0000_1040); run_cycle("R6");

    // R7: not-taken branch continues, taken branch cuts
    hit_at(32'h0000_1080);
    ctrl = 4'b0011; tkn = 4'b0010; tgt[63:32] = 32'h0000_1204;
    run_cycle("R7");
    ctrl = 0; tkn = 0; tgt = 0;

    // R8: quiesce on slot 1
    hit_at(32'h0000_1200); qz = 4'b0010; run_cycle("R8");
    qz = 0;

    // R7: taken branch to the sequential address does not cut
    hit_at(32'h0000_1200); ctrl = 4'b0001; tkn = 4'b0001;
    tgt[31:0] = pc_o + 4; run_cycle("R7");
    ctrl = 0; tkn = 0; tgt = 0;

    // R10: redirect wins over a hitting fetch
    hit_at(pc_o & ~32'(LB - 1)); redir = 1; rpc = 32'h0000_3010; rnpc = 32'h0000_3014;
    run_cycle("R10");
    redir = 0; hit_at(32'h0000_3000); run_cycle("R3");

    // Randomized mix
    for (int i = 0; i < 600; i++) begin
      en     = ($urandom % 8) != 0;
      redir  = ($urandom % 10) == 0;
      rpc    = {$urandom % 32'h0001_0000} & ~32'h3;
      rnpc   = (($urandom % 4) == 0) ? ({$urandom} & ~32'h3) : rpc + 4;
      lvalid = ($urandom % 6) != 0;
      lbase  = (($urandom % 5) != 0) ? (m_pc & ~32'(LB - 1))
                                     : ({$urandom} & ~32'(LB - 1));
      ctrl   = W'($urandom);
      tkn    = W'($urandom);
      qz     = (($urandom % 12) == 0) ? W'($urandom) : '0;
      for (int k = 0; k < W; k++)
        tgt[k*32 +: 32] = (($urandom % 3) == 0) ? 32'(m_pc + 4 * (k + 1))
                                                : ({$urandom % 32'h0001_0000} & ~32'h3);
      run_cycle("R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule